// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the scan timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe and the current pixel column and row. It advances one pixel position on each cycle in which the pixel-clock enable strobe is high. Within a line the regions follow each other as active pixels, front porch, sync pulse, back porch. Within a frame the lines follow the same order.

Software sets the scan geometry through two packed timing words, where each field is stored in a biased form, and through a control word that holds the output polarities. Software can stage a new frame buffer address at any time. The staged address becomes the active one only when the last active line of a frame finishes. That hand-over sets a status bit, which drives the interrupt line when it is enabled. A small register port handles writes and combinational reads: the timing words, the staged address, the interrupt enable, the masked status and the clear register.

Top module: `lcd_raster_timing`

## Requirements
- R1: After reset, pixX and pixY are 0, frameBase is 0 and irq is 0. The masked status reads 0. With the reset timing words, de is 1 and hsync and vsync are 0.
- R2: The horizontal word is at address 0. Bits [7:2] give the active width as (value+1)*16 pixels. Bits [23:16] give the front porch as value+1. Bits [15:8] give the sync width as value+1. Bits [31:24] give the back porch as value+1. Each line runs through active, front porch, sync and back porch, then pixX returns to 0. hsync (active high) is 1 only in the sync region.
- R3: The vertical word is at address 1. Bits [9:0] give the active lines as value+1. Bits [23:16] give the front porch in lines, with no bias. Bits [15:10] give the sync width as value+1. Bits [31:24] give the back porch in lines, with no bias. pixY advances at each line end and wraps after the last back-porch line. vsync (active high) is 1 only on sync lines.
- R4: de is 1 exactly when pixX is below the active width and pixY is below the active line count.
- R5: The control word is at address 2. Bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de. Bit 3 drives the pixClkInv output, which selects the opposite pixel-clock edge for data changes.
- R6: pixX and pixY hold while pixEn is 0 and advance by one scan position on each cycle with pixEn at 1.
- R7: A write to address 3 stages a frame address with bits [1:0] forced to 0. Reading address 3 returns the staged value. frameBase does not change until the end of the last active line, and then takes the staged value.
- R8: A hand-over of a staged address sets status bit 0. When no address has been written since the last hand-over, the end of the last active line changes neither frameBase nor the status.
- R9: The interrupt enable is bit 0 at address 4. irq and a read of address 5 bit 0 both equal the status AND the enable. Clearing the enable hides a pending status without losing it.
- R10: Writing 1 to bit 0 of address 6 clears the status, and writing 0 there has no effect. A hand-over in the same cycle as a clear leaves the status set.
- R11: Addresses 0, 1 and 4 read back the value written. Address 2 reads back bits [3:0] and the clocks-per-line field in bits [25:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixEn | input | 1 | Pixel-clock enable strobe |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 32 | Register read data (combinational) |
| hsync | output | 1 | Horizontal sync, polarity per control bit 0 |
| vsync | output | 1 | Vertical sync, polarity per control bit 1 |
| de | output | 1 | Data enable, polarity per control bit 2 |
| pixClkInv | output | 1 | Pixel-clock edge select (control bit 3) |
| pixX | output | HCW | Current column within the line |
| pixY | output | VCW | Current line within the frame |
| frameBase | output | 32 | Active frame buffer address |
| irq | output | 1 | Masked hand-over interrupt |

## Verification
The geometry is tried with four timing sets. They include a zero-length vertical porch, a single active line, a one-pixel horizontal sync and several active widths, so that a wrong bias on any one field shows up as a shifted edge or a wrong frame length. Each frame is scanned at every position against a model built from the field formulas, once at normal polarity and once with all three inversions, which separates polarity errors from placement errors. The address hand-over is placed on the exact cycle at the end of the last active line. It is then checked with the enable masked, with a zero clear, with no address staged, and with a clear that coincides with a hand-over.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

  localparam int WORD_W = 32;

  localparam logic [2:0] ADDR_HTIM = 3'd0;
  localparam logic [2:0] ADDR_VTIM = 3'd1;
  localparam logic [2:0] ADDR_CTRL = 3'd2;
  localparam logic [2:0] ADDR_BASE = 3'd3;
  localparam logic [2:0] ADDR_IEN  = 3'd4;
  localparam logic [2:0] ADDR_MSTAT = 3'd5;
  localparam logic [2:0] ADDR_ICLR = 3'd6;

  // Horizontal word bits [31:2]
  typedef struct packed {
    logic [7:0] backM1;
    logic [7:0] frontM1;
    logic [7:0] syncM1;
    logic [5:0] widthBlkM1;
  } hTim_t;

  // Vertical word, full 32 bits
  typedef struct packed {
    logic [7:0] back;
    logic [7:0] front;
    logic [5:0] syncM1;
    logic [9:0] linesM1;
  } vTim_t;

  // Strobes from scan control to register datapath
  typedef struct packed {
    logic lineEnd;
    logic onLastActLine;
  } rasterStb_t;

endpackage

// File: rtl/lrt_ctrl.sv
module lrt_ctrl
  import lrt_pkg::*;
#(
  parameter int HCW = 12,
  parameter int VCW = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pixEn,
  input  hTim_t          hTim,
  input  vTim_t          vTim,
  input  logic [2:0]     polInv,
  output rasterStb_t     stb,
  output logic           hsync,
  output logic           vsync,
  output logic           de,
  output logic [HCW-1:0] pixX,
  output logic [VCW-1:0] pixY
);

  logic [HCW-1:0] hCnt, hAct, hSyncBeg, hSyncEnd, hTotal;
  logic [VCW-1:0] vCnt, vAct, vSyncBeg, vSyncEnd, vTotal;
  logic hLast, vLast;
  logic [2:0] rawSig;

  // Horizontal limits: every field carries a minus-one bias
  assign hAct     = HCW'({hTim.widthBlkM1, 4'b0000}) + HCW'(16);
  assign hSyncBeg = hAct + HCW'(hTim.frontM1) + HCW'(1);
  assign hSyncEnd = hSyncBeg + HCW'(hTim.syncM1) + HCW'(1);
  assign hTotal   = hSyncEnd + HCW'(hTim.backM1) + HCW'(1);

  // Vertical limits: porches are unbiased
  assign vAct     = VCW'(vTim.linesM1) + VCW'(1);
  assign vSyncBeg = vAct + VCW'(vTim.front);
  assign vSyncEnd = vSyncBeg + VCW'(vTim.syncM1) + VCW'(1);
  assign vTotal   = vSyncEnd + VCW'(vTim.back);

  // >= so that a shrinking geometry still wraps
  assign hLast = hCnt >= (hTotal - HCW'(1));
  assign vLast = vCnt >= (vTotal - VCW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (pixEn) begin
      if (hLast) begin
        hCnt <= '0;
        vCnt <= vLast ? '0 : vCnt + VCW'(1);
      end else begin
        hCnt <= hCnt + HCW'(1);
      end
    end
  end

  assign stb.lineEnd       = pixEn && hLast;
  assign stb.onLastActLine = (vCnt == (vAct - VCW'(1)));

  assign rawSig[0] = (hCnt >= hSyncBeg) && (hCnt < hSyncEnd);
  assign rawSig[1] = (vCnt >= vSyncBeg) && (vCnt < vSyncEnd);
  assign rawSig[2] = (hCnt < hAct) && (vCnt < vAct);

  assign hsync = rawSig[0] ^ polInv[0];
  assign vsync = rawSig[1] ^ polInv[1];
  assign de    = rawSig[2] ^ polInv[2];
  assign pixX  = hCnt;
  assign pixY  = vCnt;

endmodule

// File: rtl/lrt_regs.sv
module lrt_regs
  import lrt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  input  rasterStb_t        stb,
  output logic [WORD_W-1:0] rdData,
  output hTim_t             hTim,
  output vTim_t             vTim,
  output logic [3:0]        polBits,
  output logic [WORD_W-1:0] frameBase,
  output logic              irq
);

  logic [9:0]        cplReg;
  logic [WORD_W-3:0] stageWord, activeWord;
  logic              stagePend, ienReg, statReg;
  logic              stageHit, clrHit, takeNow;

  assign stageHit = wrEn && (wrAddr == ADDR_BASE);
  assign clrHit   = wrEn && (wrAddr == ADDR_ICLR) && wrData[0];
  assign takeNow  = stb.lineEnd && stb.onLastActLine && stagePend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hTim       <= '0;
      vTim       <= '0;
      polBits    <= '0;
      cplReg     <= '0;
      ienReg     <= 1'b0;
      stageWord  <= '0;
      activeWord <= '0;
      stagePend  <= 1'b0;
      statReg    <= 1'b0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          ADDR_HTIM: hTim <= wrData[WORD_W-1:2];
          ADDR_VTIM: vTim <= wrData;
          ADDR_CTRL: begin
            polBits <= wrData[3:0];
            cplReg  <= wrData[25:16];
          end
          ADDR_IEN: ienReg <= wrData[0];
          default: ;
        endcase
      end
      if (stageHit) begin
        stageWord <= wrData[WORD_W-1:2];
        stagePend <= 1'b1;
      end else if (takeNow) begin
        stagePend <= 1'b0;
      end
      if (takeNow) activeWord <= stageWord;
      // A hand-over wins against a simultaneous clear
      statReg <= takeNow | (statReg & ~clrHit);
    end
  end

  assign frameBase = {activeWord, 2'b00};
  assign irq       = statReg & ienReg;

  always_comb begin
    case (rdAddr)
      ADDR_HTIM:  rdData = {hTim, 2'b00};
      ADDR_VTIM:  rdData = vTim;
      ADDR_CTRL:  rdData = {6'b0, cplReg, 12'b0, polBits};
      ADDR_BASE:  rdData = {stageWord, 2'b00};
      ADDR_IEN:   rdData = {{(WORD_W-1){1'b0}}, ienReg};
      ADDR_MSTAT: rdData = {{(WORD_W-1){1'b0}}, statReg & ienReg};
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
  import lrt_pkg::*;
#(
  parameter int HCW = 12,
  parameter int VCW = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixEn,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              pixClkInv,
  output logic [HCW-1:0]    pixX,
  output logic [VCW-1:0]    pixY,
  output logic [WORD_W-1:0] frameBase,
  output logic              irq
);

  hTim_t      hTim;
  vTim_t      vTim;
  logic [3:0] polBits;
  rasterStb_t stb;

  lrt_regs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .stb(stb), .rdData(rdData), .hTim(hTim), .vTim(vTim),
    .polBits(polBits), .frameBase(frameBase), .irq(irq)
  );

  lrt_ctrl #(.HCW(HCW), .VCW(VCW)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .hTim(hTim), .vTim(vTim),
    .polInv(polBits[2:0]), .stb(stb), .hsync(hsync), .vsync(vsync),
    .de(de), .pixX(pixX), .pixY(pixY)
  );

  assign pixClkInv = polBits[3];

endmodule

// File: rtl/lcd_raster_timing_chk.sv
module lcd_raster_timing_chk
  import lrt_pkg::*;
#(
  parameter int HCW = 12,
  parameter int VCW = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              pixEn,
  input logic              wrEn,
  input logic [2:0]        wrAddr,
  input logic [WORD_W-1:0] wrData,
  input logic              hsync,
  input logic              vsync,
  input logic              de,
  input logic [2:0]        polInv,
  input logic [HCW-1:0]    pixX,
  input logic [VCW-1:0]    pixY,
  input logic [WORD_W-1:0] frameBase,
  input logic              irq,
  input logic              swapPulse
);

  a_r6_hold_without_enable: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> ($stable(pixX) && $stable(pixY)));

  a_r7_base_only_at_swap: assert property (@(posedge clk) disable iff (!rstN)
    !swapPulse |=> $stable(frameBase));

  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(swapPulse) || $past(wrEn && wrAddr == ADDR_IEN)));

  a_r10_clear_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_ICLR && wrData[0] && !swapPulse) |=> !irq);

  a_r2_sync_outside_active: assert property (@(posedge clk) disable iff (!rstN)
    (polInv == 3'b000 && hsync) |-> !de);

  a_r3_vsync_outside_active: assert property (@(posedge clk) disable iff (!rstN)
    (polInv == 3'b000 && vsync) |-> !de);

endmodule

bind lcd_raster_timing lcd_raster_timing_chk #(.HCW(HCW), .VCW(VCW)) u_chk (
  .clk(clk), .rstN(rstN), .pixEn(pixEn), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .hsync(hsync), .vsync(vsync), .de(de),
  .polInv(polBits[2:0]), .pixX(pixX), .pixY(pixY), .frameBase(frameBase),
  .irq(irq), .swapPulse(stb.lineEnd && stb.onLastActLine)
);

// File: tb/lcd_raster_timing_tb.sv
module lcd_raster_timing_tb;
  import lrt_pkg::*;

  localparam int HCW = 12;
  localparam int VCW = 12;

  // ppl, hsw, hfp, hbp, lpp, vsw, vfp, vbp (raw field values)
  localparam int CFG [4][8] = '{
    '{0, 1, 2, 3, 2, 0, 0, 0},
    '{1, 0, 0, 0, 0, 1, 2, 1},
    '{2, 3, 5, 7, 4, 2, 1, 3},
    '{0, 7, 0, 0, 1, 0, 3, 2}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, pixEn, wrEn;
  logic [2:0] wrAddr, rdAddr;
  logic [31:0] wrData, rdData, frameBase;
  logic hsync, vsync, de, pixClkInv, irq;
  logic [HCW-1:0] pixX;
  logic [VCW-1:0] pixY;

  int nChk = 0, nFail = 0;
  int eHAct, eHss, eHse, eHTot, eVAct, eVss, eVse, eVTot;

  lcd_raster_timing #(.HCW(HCW), .VCW(VCW)) u_dut (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .hsync(hsync),
    .vsync(vsync), .de(de), .pixClkInv(pixClkInv), .pixX(pixX), .pixY(pixY),
    .frameBase(frameBase), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic setCfg(input int i);
    logic [31:0] hw, vw, rb;
    hw = (CFG[i][0] << 2) | (CFG[i][1] << 8) | (CFG[i][2] << 16) | (CFG[i][3] << 24);
    vw = CFG[i][4] | (CFG[i][5] << 10) | (CFG[i][6] << 16) | (CFG[i][7] << 24);
    eHAct = (CFG[i][0] + 1) * 16;
    eHss  = eHAct + CFG[i][2] + 1;
    eHse  = eHss + CFG[i][1] + 1;
    eHTot = eHse + CFG[i][3] + 1;
    eVAct = CFG[i][4] + 1;
    eVss  = eVAct + CFG[i][6];
    eVse  = eVss + CFG[i][5] + 1;
    eVTot = eVse + CFG[i][7];
    regWr(ADDR_HTIM, hw);
    regWr(ADDR_VTIM, vw);
    regRd(ADDR_HTIM, rb);
    chk(rb == hw, "R11 horizontal readback", rb, hw);
    regRd(ADDR_VTIM, rb);
    chk(rb == vw, "R11 vertical readback", rb, vw);
  endtask

  task automatic syncFrame();
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (pixX == 0 && pixY == 0) return;
    end
  endtask

  task automatic waitPos(input int x, input int y);
    for (int n = 0; n < 20000; n++) begin
      if (pixX == HCW'(x) && pixY == VCW'(y)) return;
      @(negedge clk);
    end
  endtask

  task automatic scanFrame(input bit iH, input bit iV, input bit iD, input string tag);
    int ePos = 0, eH = 0, eV = 0, eD = 0;
    for (int y = 0; y < eVTot; y++) begin
      for (int x = 0; x < eHTot; x++) begin
        if (pixX != HCW'(x) || pixY != VCW'(y)) ePos++;
        if (hsync != (((x >= eHss) && (x < eHse)) ^ iH)) eH++;
        if (vsync != (((y >= eVss) && (y < eVse)) ^ iV)) eV++;
        if (de != (((x < eHAct) && (y < eVAct)) ^ iD)) eD++;
        @(negedge clk);
      end
    end
    chk(ePos == 0, {"R2 R3 position sequence ", tag}, ePos, 0);
    chk(pixX == 0 && pixY == 0, {"R2 R3 frame length ", tag}, {pixY, pixX}, 0);
    chk(eH == 0, {"R2 R5 hsync ", tag}, eH, 0);
    chk(eV == 0, {"R3 R5 vsync ", tag}, eV, 0);
    chk(eD == 0, {"R4 R5 de ", tag}, eD, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rb;
    int px, py, nx, ny;
    rstN = 1'b0; pixEn = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pixX == 0 && pixY == 0, "R1 position", {pixY, pixX}, 0);
    chk(frameBase == 0, "R1 frameBase", frameBase, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk({hsync, vsync, de} == 3'b001, "R1 sync and de", {hsync, vsync, de}, 3'b001);
    regRd(ADDR_MSTAT, rb);
    chk(rb == 0, "R1 masked status", rb, 0);
    pixEn = 1'b1;

    for (int i = 0; i < 4; i++) begin
      setCfg(i);
      syncFrame();
      scanFrame(1'b0, 1'b0, 1'b0, $sformatf("cfg%0d", i));
    end

    // R5 polarity and R11 control readback
    regWr(ADDR_CTRL, (32'h2F << 16) | 32'hF);
    regRd(ADDR_CTRL, rb);
    chk(rb == 32'h002F_000F, "R11 control readback", rb, 32'h002F_000F);
    chk(pixClkInv == 1'b1, "R5 pixClkInv set", pixClkInv, 1);
    syncFrame();
    scanFrame(1'b1, 1'b1, 1'b1, "inverted");
    regWr(ADDR_CTRL, 32'h0);
    chk(pixClkInv == 1'b0, "R5 pixClkInv clear", pixClkInv, 0);

    // R6 enable strobe
    px = pixX; py = pixY;
    pixEn = 1'b0;
    repeat (7) @(negedge clk);
    chk(pixX == HCW'(px) && pixY == VCW'(py), "R6 hold when disabled", {pixY, pixX}, {py[11:0], px[11:0]});
    pixEn = 1'b1;
    @(negedge clk);
    pixEn = 1'b0;
    nx = (px + 1 == eHTot) ? 0 : px + 1;
    ny = (px + 1 == eHTot) ? ((py + 1 == eVTot) ? 0 : py + 1) : py;
    @(negedge clk);
    chk(pixX == HCW'(nx) && pixY == VCW'(ny), "R6 single step", {pixY, pixX}, {ny[11:0], nx[11:0]});
    pixEn = 1'b1;

    // R7 R8 R9 staged base hand-over (config 3 active)
    regWr(ADDR_IEN, 32'h1);
    regRd(ADDR_IEN, rb);
    chk(rb == 1, "R11 enable readback", rb, 1);
    regWr(ADDR_BASE, 32'h0000_1237);
    regRd(ADDR_BASE, rb);
    chk(rb == 32'h1234, "R7 staged alignment", rb, 32'h1234);
    chk(frameBase == 0, "R7 not taken at write", frameBase, 0);
    waitPos(eHTot - 1, eVAct - 1);
    chk(frameBase == 0 && irq == 0, "R7 held until line end", frameBase, 0);
    @(negedge clk);
    chk(frameBase == 32'h1234, "R7 taken at last active line end", frameBase, 32'h1234);
    chk(irq == 1, "R8 hand-over interrupt", irq, 1);
    regRd(ADDR_MSTAT, rb);
    chk(rb == 1, "R9 masked status set", rb, 1);
    regWr(ADDR_IEN, 32'h0);
    regRd(ADDR_MSTAT, rb);
    chk(irq == 0 && rb == 0, "R9 masked by enable", {irq, rb[0]}, 0);
    regWr(ADDR_IEN, 32'h1);
    chk(irq == 1, "R9 status retained under mask", irq, 1);
    regWr(ADDR_ICLR, 32'h0);
    chk(irq == 1, "R10 zero clear ignored", irq, 1);
    regWr(ADDR_ICLR, 32'h1);
    chk(irq == 0, "R10 clear", irq, 0);

    // R8 no hand-over without staging
    waitPos(eHTot - 1, eVAct - 1);
    @(negedge clk);
    chk(frameBase == 32'h1234 && irq == 0, "R8 no stage no swap", {irq, frameBase}, 32'h1234);

    // R10 clear colliding with hand-over
    regWr(ADDR_BASE, 32'h0000_ABCC);
    waitPos(eHTot - 1, eVAct - 1);
    wrEn = 1'b1; wrAddr = ADDR_ICLR; wrData = 32'h1;
    @(negedge clk);
    wrEn = 1'b0;
    chk(irq == 1, "R10 set wins over clear", irq, 1);
    chk(frameBase == 32'hABCC, "R7 second hand-over", frameBase, 32'hABCC);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule